// File: doc/BRIEF.md
# Full-Speed Serial Bus Bit-Level Transmitter

This block turns a stream of bytes from a processor into the line signalling of a two-wire differential serial bus, at 12 Mbit/s full speed or with low-speed polarity. Software hands over whole bytes through a ready/valid port. The block generates everything below the byte level. It sends the sync field first, then NRZI-encodes every bit. It inserts a stuffed zero after each run of six ones. It closes the packet with a single-ended-zero end marker and one bit of idle, and then releases the pair.

The bit period comes from a 16-bit phase accumulator clocked by the system clock. The accumulator adds `nco_inc` every cycle, and each carry out of the top bit ends one bit time. Any system clock can therefore reach the bus rate. The nominal setting is `nco_inc = round(65536 * 12 MHz / f_clk)`. The accumulator is held at zero while idle, so every packet starts on a fresh bit boundary.

A single holding slot sits between the byte port and the shift register. When the last bit of a byte goes out and no further byte is held or offered, the packet ends. Running out of data is therefore the normal way to end a packet. CRC, PID choice, scheduling and reception belong to software or to other blocks.

Top module: `usbfs_tx_serializer`

## Requirements
- R1: After synchronous reset, `usb_oe` is 0, `tx_ready` is 1, `tx_done` is 0, and the pins show full-speed J (`usb_dp`=1, `usb_dm`=0).
- R2: Each bit time lasts until the 16-bit accumulator, which starts at zero when a packet starts, carries out. With `nco_inc` = 65536/K this is exactly K clock cycles, and the packet holds `usb_oe` high for (bit times) x K cycles.
- R3: Every packet begins with the sync field: seven zero bits then a one bit, which from idle J appears on the line as K J K J K J K K.
- R4: Encoding is NRZI. A zero bit toggles the line between J and K, and a one bit keeps the previous state.
- R5: Data bits go out least significant bit first. Consecutive bytes follow with no gap and no framing bits.
- R6: After six consecutive one bits, one extra zero bit is sent. The run count continues across sync and byte boundaries and clears on any zero, stuffed ones included. A run of six ending on the last data bit is also stuffed before the end marker.
- R7: A packet ends with two bit times of SE0 (both pins 0), then one bit time of J. After that, `usb_oe` drops and `tx_done` is 1 for exactly that first idle cycle.
- R8: A byte is appended to the packet only if it is held or handshaked by the tick that ends the current byte (and its stuffed bit). Otherwise the transmitter goes straight to the end marker.
- R9: `tx_ready` is 1 while idle and while sending with the holding slot empty. It is 0 while the slot is full and throughout the end marker. A handshake while idle starts a packet, and that byte is held during sync.
- R10: With `low_speed`=0, J is `usb_dp`=1/`usb_dm`=0. With `low_speed`=1, J is `usb_dp`=0/`usb_dm`=1. K is the opposite pair, and both pins are never 1 together.
- R11: While `usb_oe` is high, the pins change only at the clock edge that follows a bit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nco_inc | input | 16 | Phase increment per clock; bit rate = f_clk * nco_inc / 65536 |
| low_speed | input | 1 | Selects low-speed J/K polarity |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts `tx_data` on this edge when `tx_valid` is high |
| tx_done | output | 1 | One-cycle pulse when the pair is released after a packet |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Drive enable for the pair; 0 means tristate |

## Verification
The first bit symbol appears one clock after the handshake that starts a packet, and each later symbol holds for exactly K cycles. The bench uses power-of-two increments so that K is an integer. It records the pins on every falling edge and reads each symbol in the middle of its K-cycle slot, which keeps every comparison clear of the bit edges. It checks the released cycle for the one-cycle `tx_done` and compares the total driven length against the expected number of bit times times K. Handshake counts are sampled a fixed number of cycles after the start, chosen well inside the 8K-cycle sync field and the following byte.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_SE0,
        ST_JEND
    } tx_state_e;

    // Longest run of ones before a zero is forced onto the line
    localparam int STUFF_RUN = 6;

    typedef struct packed {
        logic dp;
        logic dm;
    } pin_pair_t;

    // Map the abstract line level (J or K) and SE0 onto the two wires
    function automatic pin_pair_t map_pins(logic se0, logic level_j, logic ls_mode);
        pin_pair_t p;
        logic dp_lvl;
        dp_lvl = level_j ^ ls_mode;
        if (se0) begin
            p.dp = 1'b0;
            p.dm = 1'b0;
        end else begin
            p.dp = dp_lvl;
            p.dm = ~dp_lvl;
        end
        return p;
    endfunction

endpackage

// File: rtl/usbtx_nco.sv
module usbtx_nco #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc} + {1'b0, inc};
    assign tick = run & sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/usbtx_nrzi_stuff.sv
module usbtx_nrzi_stuff #(
    parameter int RUN = usbtx_pkg::STUFF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic set_j,
    input  logic emit,
    input  logic bit_val,
    output logic line_j,
    output logic stuff_due
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones;

    assign stuff_due = (ones == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst || set_j) begin
            line_j <= 1'b1;
            ones   <= '0;
        end else if (emit) begin
            if (bit_val) begin
                ones <= ones + 1'b1;
            end else begin
                line_j <= ~line_j;
                ones   <= '0;
            end
        end
    end
endmodule

// File: rtl/usbtx_pin_drive.sv
module usbtx_pin_drive (
    input  logic active,
    input  logic se0,
    input  logic line_j,
    input  logic low_speed,
    output logic dp,
    output logic dm,
    output logic oe
);
    import usbtx_pkg::*;

    pin_pair_t pins;

    always_comb begin
        pins = map_pins(se0, line_j, low_speed);
        dp   = pins.dp;
        dm   = pins.dm;
        oe   = active;
    end
endmodule

// File: rtl/usbfs_tx_serializer.sv
module usbfs_tx_serializer #(
    parameter int NCO_W    = 16,
    parameter int DATA_W   = 8,
    parameter int SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCO_W-1:0]  nco_inc,
    input  logic              low_speed,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_done,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe
);
    import usbtx_pkg::*;

    localparam int                IDX_W     = $clog2(DATA_W);
    localparam int                SE0_W     = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(DATA_W - 1);
    localparam logic [SE0_W-1:0]  SE0_LAST  = SE0_W'(SE0_BITS - 1);
    localparam logic [DATA_W-1:0] SYNC_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] hold;
    logic              hold_full;
    logic [SE0_W-1:0]  se0_cnt;
    logic              done_r;

    logic              bit_tick;
    logic              take;
    logic              avail;
    logic [DATA_W-1:0] next_byte;
    logic              last_bit;
    logic              enc_set_j;
    logic              enc_emit;
    logic              enc_bit;
    logic              line_j;
    logic              stuff_due;

    usbtx_nco #(.ACC_W(NCO_W)) u_nco (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .inc  (nco_inc),
        .tick (bit_tick)
    );

    usbtx_nrzi_stuff #(.RUN(STUFF_RUN)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .set_j     (enc_set_j),
        .emit      (enc_emit),
        .bit_val   (enc_bit),
        .line_j    (line_j),
        .stuff_due (stuff_due)
    );

    usbtx_pin_drive u_pins (
        .active    (state != ST_IDLE),
        .se0       (state == ST_SE0),
        .line_j    (line_j),
        .low_speed (low_speed),
        .dp        (usb_dp),
        .dm        (usb_dm),
        .oe        (usb_oe)
    );

    assign tx_ready  = (state == ST_IDLE) || ((state == ST_SEND) && !hold_full);
    assign take      = tx_valid && tx_ready;
    assign avail     = hold_full || take;
    assign next_byte = hold_full ? hold : tx_data;
    assign last_bit  = (bidx == IDX_LAST);
    assign tx_done   = done_r;

    // Select the bit that enters the encoder on each bit boundary
    always_comb begin
        enc_set_j = 1'b0;
        enc_emit  = 1'b0;
        enc_bit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                enc_set_j = !take;
                enc_emit  = take;
                enc_bit   = SYNC_WORD[0];
            end
            ST_SEND: begin
                if (bit_tick) begin
                    if (stuff_due) begin
                        enc_emit = 1'b1;
                        enc_bit  = 1'b0;
                    end else if (!last_bit) begin
                        enc_emit = 1'b1;
                        enc_bit  = shreg[1];
                    end else if (avail) begin
                        enc_emit = 1'b1;
                        enc_bit  = next_byte[0];
                    end
                end
            end
            ST_SE0: begin
                enc_set_j = bit_tick && (se0_cnt == SE0_LAST);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bidx      <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            se0_cnt   <= '0;
            done_r    <= 1'b0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        state     <= ST_SEND;
                        shreg     <= SYNC_WORD;
                        bidx      <= '0;
                        hold      <= tx_data;
                        hold_full <= 1'b1;
                    end
                end
                ST_SEND: begin
                    if (take) begin
                        hold      <= tx_data;
                        hold_full <= 1'b1;
                    end
                    if (bit_tick && !stuff_due) begin
                        if (!last_bit) begin
                            shreg <= shreg >> 1;
                            bidx  <= bidx + 1'b1;
                        end else if (avail) begin
                            shreg     <= next_byte;
                            bidx      <= '0;
                            hold_full <= 1'b0;
                        end else begin
                            state   <= ST_SE0;
                            se0_cnt <= '0;
                        end
                    end
                end
                ST_SE0: begin
                    if (bit_tick) begin
                        if (se0_cnt == SE0_LAST) begin
                            state <= ST_JEND;
                        end else begin
                            se0_cnt <= se0_cnt + 1'b1;
                        end
                    end
                end
                ST_JEND: begin
                    if (bit_tick) begin
                        state  <= ST_IDLE;
                        done_r <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbtx_serializer_chk.sv
module usbtx_serializer_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic tx_ready,
    input logic tx_done,
    input logic usb_dp,
    input logic usb_dm,
    input logic usb_oe
);
    logic [1:0] sym_prev;
    logic [3:0] run_len;
    logic       tick_d;
    logic       oe_d;

    // Length of the current run of unchanged J/K symbols on the wires
    always_ff @(posedge clk) begin
        if (rst) begin
            sym_prev <= 2'b10;
            run_len  <= '0;
            tick_d   <= 1'b0;
            oe_d     <= 1'b0;
        end else begin
            tick_d <= bit_tick;
            oe_d   <= usb_oe;
            if (!usb_oe) begin
                sym_prev <= {usb_dp, usb_dm};
                run_len  <= '0;
            end else if (tick_d || !oe_d) begin
                sym_prev <= {usb_dp, usb_dm};
                if ({usb_dp, usb_dm} == 2'b00) begin
                    run_len <= '0;
                end else if ({usb_dp, usb_dm} == sym_prev) begin
                    run_len <= run_len + 1'b1;
                end else begin
                    run_len <= '0;
                end
            end
        end
    end

    assert_pins_legal_R10: assert property (@(posedge clk) disable iff (rst)
        !(usb_dp && usb_dm));

    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (rst)
        (usb_oe && !bit_tick) |=> $stable({usb_dp, usb_dm}));

    assert_done_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(usb_oe) |-> tx_done);

    assert_done_only_idle_R7: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !usb_oe);

    assert_no_ready_in_eop_R9: assert property (@(posedge clk) disable iff (rst)
        (usb_oe && !usb_dp && !usb_dm) |-> !tx_ready);

    assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !usb_oe |-> tx_ready);

    assert_stuff_run_R6: assert property (@(posedge clk) disable iff (rst)
        run_len <= 4'd6);

endmodule

bind usbfs_tx_serializer usbtx_serializer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .usb_dp   (usb_dp),
    .usb_dm   (usb_dm),
    .usb_oe   (usb_oe)
);

// File: tb/tb_usbfs_tx_serializer.sv
module tb_usbfs_tx_serializer;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] nco_inc;
    logic        low_speed;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        tx_done;
    logic        usb_dp;
    logic        usb_dm;
    logic        usb_oe;

    always #10 clk = ~clk;

    usbfs_tx_serializer dut (
        .clk       (clk),
        .rst       (rst),
        .nco_inc   (nco_inc),
        .low_speed (low_speed),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_done   (tx_done),
        .usb_dp    (usb_dp),
        .usb_dm    (usb_dm),
        .usb_oe    (usb_oe)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] pk [0:15];
    int         pk_n;
    logic [1:0] cap [0:4095];
    int         cap_len;
    logic       done_seen;
    int         acc_cnt;
    int         exp_sym [0:1023];
    int         exp_n;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Expected symbol list: 0 = SE0, 1 = J, 2 = K
    function automatic void build_expected();
        int line;
        int ones;
        logic [7:0] v;
        line  = 1;
        ones  = 0;
        exp_n = 0;
        for (int b = 0; b <= pk_n; b++) begin
            v = (b == 0) ? 8'h80 : pk[b-1];
            for (int i = 0; i < 8; i++) begin
                if (v[i]) begin
                    ones++;
                end else begin
                    line = 1 - line;
                    ones = 0;
                end
                exp_sym[exp_n] = line ? 1 : 2;
                exp_n++;
                if (ones == 6) begin
                    line = 1 - line;
                    ones = 0;
                    exp_sym[exp_n] = line ? 1 : 2;
                    exp_n++;
                end
            end
        end
        exp_sym[exp_n] = 0; exp_n++;
        exp_sym[exp_n] = 0; exp_n++;
        exp_sym[exp_n] = 1; exp_n++;
    endfunction

    function automatic int pins_code(logic [1:0] p, bit ls);
        logic [1:0] jp;
        jp = ls ? 2'b01 : 2'b10;
        if (p == 2'b00) return 0;
        if (p == jp) return 1;
        if (p == ~jp) return 2;
        return 3;
    endfunction

    function automatic int decoded(int j, int k, bit ls);
        int idx;
        idx = j * k + k / 2;
        if (idx >= cap_len || idx >= 4096) return 4;
        return pins_code(cap[idx], ls);
    endfunction

    task automatic run_packet(int k, bit ls, int gap, string tag);
        int bad_at;
        int ok_sync;
        nco_inc   = 16'(65536 / k);
        low_speed = ls;
        cap_len   = 0;
        done_seen = 1'b0;
        acc_cnt   = 0;
        fork
            begin
                for (int i = 0; i < pk_n; i++) begin
                    if (i > 0) begin
                        repeat (gap) begin
                            @(negedge clk);
                            tx_valid = 1'b0;
                        end
                    end
                    do begin
                        @(negedge clk);
                        tx_valid = 1'b1;
                        tx_data  = pk[i];
                    end while (!tx_ready);
                    acc_cnt++;
                end
                @(negedge clk);
                tx_valid = 1'b0;
            end
            begin
                bit started;
                int guard;
                started = 1'b0;
                guard   = 0;
                while (guard < 20000) begin
                    @(negedge clk);
                    guard++;
                    if (usb_oe) begin
                        started = 1'b1;
                        if (cap_len < 4096) cap[cap_len] = {usb_dp, usb_dm};
                        cap_len++;
                    end else if (started) begin
                        done_seen = tx_done;
                        break;
                    end
                end
            end
        join
        build_expected();
        // R2: driven length equals bit times times K
        check(cap_len == exp_n * k, "R2", "driven cycles", cap_len, exp_n * k);
        // R3: sync field
        ok_sync = 1;
        for (int j = 0; j < 8; j++) begin
            if (decoded(j, k, ls) != exp_sym[j]) ok_sync = 0;
        end
        check(ok_sync == 1, "R3", "sync symbols match", ok_sync, 1);
        // Data symbols (NRZI, bit order, stuffing, underflow)
        bad_at = -1;
        for (int j = 8; j < exp_n - 3; j++) begin
            if (bad_at < 0 && decoded(j, k, ls) != exp_sym[j]) bad_at = j;
        end
        if (bad_at >= 0)
            check(1'b0, tag, "data symbol", decoded(bad_at, k, ls), exp_sym[bad_at]);
        else
            check(1'b1, tag, "data symbols", 0, 0);
        // R7: end marker and release
        check(decoded(exp_n - 3, k, ls) == 0 && decoded(exp_n - 2, k, ls) == 0,
              "R7", "SE0 pair", decoded(exp_n - 2, k, ls), 0);
        check(decoded(exp_n - 1, k, ls) == 1, "R7", "J after SE0", decoded(exp_n - 1, k, ls), 1);
        check(done_seen == 1'b1, "R7", "done on release", int'(done_seen), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int snap1;
        int snap2;
        int ks [0:2];
        ks[0] = 2; ks[1] = 4; ks[2] = 8;
        void'($urandom(32'd24681));
        rst       = 1'b1;
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        nco_inc   = 16'h4000;
        low_speed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(usb_oe == 1'b0, "R1", "oe after reset", int'(usb_oe), 0);
        check(tx_ready == 1'b1, "R1", "ready after reset", int'(tx_ready), 1);
        check(tx_done == 1'b0, "R1", "done after reset", int'(tx_done), 0);
        check({usb_dp, usb_dm} == 2'b10, "R1", "idle pins", int'({usb_dp, usb_dm}), 2);

        // R4 R5: two bytes, K = 4
        pk_n = 2; pk[0] = 8'hA5; pk[1] = 8'h3C;
        run_packet(4, 1'b0, 0, "R5");

        // R6: long run of ones across a byte boundary
        pk_n = 3; pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h01;
        run_packet(4, 1'b0, 0, "R6");

        // R6: six ones end the last byte, stuffed before the end marker
        pk_n = 2; pk[0] = 8'h00; pk[1] = 8'hFC;
        run_packet(4, 1'b0, 0, "R6");

        // R10 R2: low-speed polarity, K = 2
        pk_n = 2; pk[0] = 8'h5A; pk[1] = 8'hC3;
        run_packet(2, 1'b1, 0, "R10");

        // R2 R4: slow rate, K = 8
        pk_n = 1; pk[0] = 8'h0F;
        run_packet(8, 1'b0, 0, "R4");

        // R8: single byte, source then runs dry
        pk_n = 1; pk[0] = 8'hE7;
        run_packet(4, 1'b0, 0, "R8");

        // R8: short gaps between bytes still inside the byte window
        pk_n = 3; pk[0] = 8'h12; pk[1] = 8'h34; pk[2] = 8'h56;
        run_packet(4, 1'b0, 6, "R8");

        // R9: slot holds first byte through sync
        pk_n = 3; pk[0] = 8'h81; pk[1] = 8'h42; pk[2] = 8'h24;
        fork
            run_packet(4, 1'b0, 0, "R9");
            begin
                repeat (12) @(negedge clk);
                #1 snap1 = acc_cnt;
                repeat (30) @(negedge clk);
                #1 snap2 = acc_cnt;
            end
        join
        check(snap1 == 1, "R9", "bytes taken during sync", snap1, 1);
        check(snap2 == 2, "R9", "bytes taken during first byte", snap2, 2);

        // Random packets
        for (int t = 0; t < 8; t++) begin
            int kk;
            bit ls;
            int gp;
            pk_n = 1 + int'($urandom % 6);
            for (int b = 0; b < pk_n; b++) pk[b] = 8'($urandom);
            kk = ks[$urandom % 3];
            ls = 1'($urandom);
            gp = int'($urandom % 4);
            run_packet(kk, ls, gp, "R5");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule